// File: doc/BRIEF.md
# Sequential Nonrestoring Signed/Unsigned Divider

This block divides a 2K-bit dividend by a K-bit divisor one quotient bit per clock, producing a K-bit quotient and a K-bit remainder. A mode input picks between two's-complement and plain binary operands. Every iteration doubles the partial remainder and then either subtracts or adds the divisor, aligned to the upper half. The choice depends only on whether the remainder's sign matches the divisor's sign. Nothing is ever restored. The digits form a string over {-1, +1}. A last cycle turns that string into a two's-complement quotient and applies a one-step sign correction to the remainder.

Before any iteration starts, the block screens out a zero divisor and a quotient that would not fit in K bits. Either condition raises a flag, returns zeros and completes on the next cycle. The operands are captured on the accepted start pulse, so the caller may change them afterwards. To make one datapath serve both modes, the core is built one bit wider than K (K+1 iterations).

Top module: `nr_divider`

## Requirements
- R1: With signed_i = 1 (both operands two's complement), a completed division returns quot_o and rem_o such that dividend = divisor × quotient + remainder, the quotient is truncated toward zero, the remainder is zero or has the dividend's sign, and |remainder| < |divisor|. For example, with K = 4, 33 / -7 gives -4 rem 5 and -5 / 3 gives -1 rem -2.
- R2: With signed_i = 0 (both operands unsigned), the outputs are the unsigned quotient and remainder. For example, with K = 4, 117 / 10 gives 11 rem 7.
- R3: In signed mode, when the true quotient lies outside [-2^(K-1), 2^(K-1)-1], ovf_o = 1 and div_zero_o = 0. No iteration runs: done_o pulses on the cycle after start is sampled, with quot_o = 0 and rem_o = 0.
- R4: In unsigned mode, ovf_o = 1 exactly when the upper K dividend bits are greater than or equal to the divisor. Timing and zeroed results are as in R3.
- R5: A zero divisor sets div_zero_o = 1 and leaves ovf_o = 0, in either mode. No iteration runs: done_o pulses on the next cycle with zeroed results and busy_o stays low.
- R6: An accepted start (start_i = 1 while busy_o = 0, no error) raises busy_o for exactly K+2 cycles. done_o rises on the (K+3)th rising edge, counting the edge that samples start_i as the first, and busy_o falls on that same edge.
- R7: done_o is high for one cycle per completion. quot_o, rem_o, div_zero_o and ovf_o hold their values until the next completion.
- R8: A start_i pulse while busy_o = 1 is ignored: neither the running result nor its timing changes.
- R9: After reset, busy_o, done_o, quot_o, rem_o, div_zero_o and ovf_o are all 0.
- R10: The edge cases are exact. A zero dividend gives 0 rem 0. A signed quotient of exactly -2^(K-1) (for example -8/1 and 8/-1 with K = 4) is not an overflow. Exact negative divisions return a zero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend_i | input | 2K | Dividend |
| divisor_i | input | K | Divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | K | Quotient |
| rem_o | output | K | Remainder |
| div_zero_o | output | 1 | Last operation had a zero divisor |
| ovf_o | output | 1 | Last operation's quotient did not fit |

## Verification
The bench builds the block with WIDTH_K = 4, which makes the operand space small enough to sweep every 8-bit dividend against every 4-bit divisor in both modes. That sweep reaches every overflow boundary, every most-negative quotient, every case where the corrective add or subtract fires, and the case where the raw remainder equals minus the divisor. Directed operations cover the stated example vectors, a start pulse during an operation, and result holding between operations.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/nr_div_check.sv
// Pre-screen: zero divisor and quotient range, compared on magnitudes.
module nr_div_check #(
  parameter int K = 8
) (
  input  logic [2*K-1:0] dividend_i,
  input  logic [K-1:0]   divisor_i,
  input  logic           signed_i,
  output logic           zero_o,
  output logic           ovf_o
);
  localparam int LW = 2*K+1;

  logic           dvd_neg, dvs_neg, neg_res;
  logic [2*K-1:0] mag_z;
  logic [K-1:0]   mag_d;
  logic [LW-1:0]  md_x, lim;

  always_comb begin
    dvd_neg = signed_i & dividend_i[2*K-1];
    dvs_neg = signed_i & divisor_i[K-1];
    neg_res = dvd_neg ^ dvs_neg;
    mag_z   = dvd_neg ? -dividend_i : dividend_i;
    mag_d   = dvs_neg ? -divisor_i  : divisor_i;
    md_x    = LW'(mag_d);
    // negative quotient may reach -2^(K-1): limit grows by one divisor
    if (signed_i) lim = (md_x << (K-1)) + (neg_res ? md_x : '0);
    else          lim = md_x << K;
    zero_o = (divisor_i == '0);
    ovf_o  = !zero_o && ({1'b0, mag_z} >= lim);
  end
endmodule

// File: rtl/nr_div_step.sv
// One radix-2 nonrestoring iteration.
module nr_div_step #(
  parameter int W = 9
) (
  input  logic [2*W:0] rem_i,
  input  logic [W-1:0] dvs_i,
  output logic [2*W:0] rem_o,
  output logic         digit_o
);
  localparam int RW = 2*W+1;

  logic [RW-1:0] aligned, shifted;

  always_comb begin
    aligned = {{(RW-W){dvs_i[W-1]}}, dvs_i} << W;
    shifted = {rem_i[RW-2:0], 1'b0};
    digit_o = (rem_i[RW-1] == dvs_i[W-1]);
    rem_o   = digit_o ? shifted - aligned : shifted + aligned;
  end
endmodule

// File: rtl/nr_div_fixup.sv
// Digit-string conversion and one-step remainder sign correction.
module nr_div_fixup #(
  parameter int K = 8,
  parameter int W = K+1
) (
  input  logic [W:0]   rem_hi_i,
  input  logic [W-1:0] digits_i,
  input  logic [W-1:0] dvs_i,
  input  logic         z_neg_i,
  output logic [K-1:0] quot_o,
  output logic [K-1:0] rem_o
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W:0] d_x, q_raw, q_fin, r_fin;
  logic       r_nz, r_neg, mag_eq, fix, toward;

  always_comb begin
    d_x    = {dvs_i[W-1], dvs_i};
    q_raw  = {~digits_i[W-1], digits_i[W-2:0], 1'b1};
    r_nz   = |rem_hi_i;
    r_neg  = rem_hi_i[W];
    mag_eq = ((rem_hi_i + d_x) == '0) || ((rem_hi_i - d_x) == '0);
    fix    = r_nz && ((r_neg != z_neg_i) || mag_eq);
    toward = (r_neg == d_x[W]);
    r_fin  = rem_hi_i;
    q_fin  = q_raw;
    if (fix) begin
      r_fin = toward ? rem_hi_i - d_x : rem_hi_i + d_x;
      q_fin = toward ? q_raw + ONE   : q_raw - ONE;
    end
    quot_o = q_fin[K-1:0];
    rem_o  = r_fin[K-1:0];
  end
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int WIDTH_K = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 signed_i,
  input  logic [2*WIDTH_K-1:0] dividend_i,
  input  logic [WIDTH_K-1:0]   divisor_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [WIDTH_K-1:0]   quot_o,
  output logic [WIDTH_K-1:0]   rem_o,
  output logic                 div_zero_o,
  output logic                 ovf_o
);
  localparam int K   = WIDTH_K;
  localparam int W   = K+1;          // one guard bit serves both modes
  localparam int RW  = 2*W+1;
  localparam int EXT = RW-2*K;
  localparam int CW  = $clog2(W+1);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rem_q, step_rem;
  logic [W-1:0]  dig_q, dvs_q;
  logic          z_neg_q, sgn_q, step_dig;
  logic          done_q, dz_q, ov_q;
  logic [K-1:0]  quot_q, res_rem_q, fx_quot, fx_rem;
  logic          chk_zero, chk_ovf;
  logic [RW-1:0] z_ext;
  logic [W-1:0]  dvs_ext;

  nr_div_check #(.K(K)) u_check (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .signed_i   (signed_i),
    .zero_o     (chk_zero),
    .ovf_o      (chk_ovf)
  );

  nr_div_step #(.W(W)) u_step (
    .rem_i   (rem_q),
    .dvs_i   (dvs_q),
    .rem_o   (step_rem),
    .digit_o (step_dig)
  );

  nr_div_fixup #(.K(K), .W(W)) u_fix (
    .rem_hi_i (rem_q[RW-1:W]),
    .digits_i (dig_q),
    .dvs_i    (dvs_q),
    .z_neg_i  (z_neg_q),
    .quot_o   (fx_quot),
    .rem_o    (fx_rem)
  );

  always_comb begin
    z_ext   = {{EXT{signed_i & dividend_i[2*K-1]}}, dividend_i};
    dvs_ext = {signed_i & divisor_i[K-1], divisor_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rem_q     <= '0;
      dig_q     <= '0;
      dvs_q     <= '0;
      z_neg_q   <= 1'b0;
      sgn_q     <= 1'b0;
      done_q    <= 1'b0;
      dz_q      <= 1'b0;
      ov_q      <= 1'b0;
      quot_q    <= '0;
      res_rem_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sgn_q <= signed_i;
          if (chk_zero || chk_ovf) begin
            done_q    <= 1'b1;
            dz_q      <= chk_zero;
            ov_q      <= chk_ovf;
            quot_q    <= '0;
            res_rem_q <= '0;
          end else begin
            state_q <= ST_ITER;
            cnt_q   <= '0;
            rem_q   <= z_ext;
            dvs_q   <= dvs_ext;
            dig_q   <= '0;
            z_neg_q <= signed_i & dividend_i[2*K-1];
          end
        end
        ST_ITER: begin
          rem_q <= step_rem;
          dig_q <= {dig_q[W-2:0], step_dig};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          state_q   <= ST_IDLE;
          done_q    <= 1'b1;
          dz_q      <= 1'b0;
          ov_q      <= 1'b0;
          quot_q    <= fx_quot;
          res_rem_q <= fx_rem;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign quot_o     = quot_q;
  assign rem_o      = res_rem_q;
  assign div_zero_o = dz_q;
  assign ovf_o      = ov_q;

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o != done_o)); // R6
  AST_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o); // R7
  AST_REM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sgn_q && !div_zero_o && !ovf_o && rem_o != '0) |-> (rem_o[K-1] == z_neg_q)); // R1
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (div_zero_o || ovf_o)) |-> (quot_o == '0 && rem_o == '0)); // R3
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(div_zero_o && ovf_o)); // R5
endmodule

// File: tb/nr_divider_tb.sv
`timescale 1ns/1ps
module nr_divider_tb;
  localparam int K  = 4;
  localparam int ZW = 2*K;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          signed_i = 1'b0;
  logic [ZW-1:0] dividend_i = '0;
  logic [K-1:0]  divisor_i = '0;
  logic          busy_o, done_o, div_zero_o, ovf_o;
  logic [K-1:0]  quot_o, rem_o;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R9";

  always #2.5 clk = ~clk;

  nr_divider #(.WIDTH_K(K)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .busy_o(busy_o),
    .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
    .div_zero_o(div_zero_o), .ovf_o(ovf_o)
  );

  // behavioural reference, advanced on rising edges
  logic         m_busy, m_done, m_dz, m_ov;
  logic [K-1:0] m_q, m_r, p_q, p_r;
  int           m_cnt;
  string        m_req, p_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_ov = 0; m_q = '0; m_r = '0;
      m_cnt = 0; m_req = "R9";
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
          m_dz = 0; m_ov = 0; m_req = p_req;
        end
      end else if (start_i) begin
        int zi, di, qi, ri;
        logic dz, ov;
        if (signed_i) begin
          zi = int'($signed(dividend_i)); di = int'($signed(divisor_i));
        end else begin
          zi = int'(dividend_i); di = int'(divisor_i);
        end
        dz = (di == 0); ov = 0; qi = 0; ri = 0;
        if (!dz) begin
          qi = zi / di; ri = zi % di;
          ov = signed_i ? (qi < -(1 << (K-1)) || qi > (1 << (K-1)) - 1)
                        : (qi > (1 << K) - 1);
        end
        if (dz || ov) begin
          m_done = 1; m_q = '0; m_r = '0; m_dz = dz; m_ov = ov;
          m_req = dz ? "R5" : (signed_i ? "R3" : "R4");
        end else begin
          m_busy = 1; m_cnt = K + 2;
          p_q = K'(qi); p_r = K'(ri);
          p_req = signed_i ? "R1" : "R2";
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (busy_o !== m_busy || done_o !== m_done) begin
        n_fail++;
        $display("FAIL R6/R7 [%s] busy,done act=%b%b exp=%b%b", cur_tag,
                 busy_o, done_o, m_busy, m_done);
      end
      n_checks++;
      if ({quot_o, rem_o, div_zero_o, ovf_o} !== {m_q, m_r, m_dz, m_ov}) begin
        n_fail++;
        $display("FAIL %s [%s] q,r,dz,ov act=%0d,%0d,%b,%b exp=%0d,%0d,%b,%b",
                 m_req, cur_tag, quot_o, rem_o, div_zero_o, ovf_o,
                 m_q, m_r, m_dz, m_ov);
      end
    end
  end

  task automatic run_op(input logic [ZW-1:0] z, input logic [K-1:0] d,
                        input logic s, input string tag);
    cur_tag = tag;
    @(negedge clk);
    dividend_i = z; divisor_i = d; signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; dividend_i = ~z; divisor_i = ~d; signed_i = ~s;
    for (int i = 0; i < K + 8 && !done_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if ({busy_o, done_o, quot_o, rem_o, div_zero_o, ovf_o} !== '0) begin
      n_fail++;
      $display("FAIL R9 reset outputs act=%b%b %0d %0d %b%b exp=all zero",
               busy_o, done_o, quot_o, rem_o, div_zero_o, ovf_o);
    end
    rst_n = 1'b1;

    run_op(8'd33,  4'b1001, 1'b1, "R1 33/-7");
    run_op(8'hFB,  4'd3,    1'b1, "R1 -5/3");
    run_op(8'd117, 4'd10,   1'b0, "R2 117/10");
    run_op(8'd64,  4'd2,    1'b1, "R3 64/2");
    run_op(8'h80,  4'hF,    1'b1, "R3 -128/-1");
    run_op(8'd160, 4'd10,   1'b0, "R4 160/10");
    run_op(8'd159, 4'd10,   1'b0, "R4 159/10");
    run_op(8'd77,  4'd0,    1'b1, "R5 signed zero");
    run_op(8'd77,  4'd0,    1'b0, "R5 unsigned zero");
    run_op(8'd0,   4'd5,    1'b1, "R10 zero dividend");
    run_op(8'hF8,  4'd1,    1'b1, "R10 -8/1");
    run_op(8'd8,   4'hF,    1'b1, "R10 8/-1");
    run_op(8'hEB,  4'b1001, 1'b1, "R10 -21/-7");

    // R8: second start while busy must not disturb the first operation
    cur_tag = "R8";
    @(negedge clk);
    dividend_i = 8'd100; divisor_i = 4'd7; signed_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    dividend_i = 8'd3; divisor_i = 4'd0; signed_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < K + 8 && !done_o; i++) @(negedge clk);
    cur_tag = "R7 hold";
    repeat (6) @(negedge clk);

    for (int s = 0; s < 2; s++)
      for (int z = 0; z < (1 << ZW); z++)
        for (int d = 0; d < (1 << K); d++)
          run_op(ZW'(z), K'(d), s[0], s[0] ? "R1 sweep" : "R2 sweep");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog [%s] act=running exp=finished", cur_tag);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule